// File: doc/BRIEF.md
# UART Receive Idle and Break Monitor

This block sits beside a UART receiver and watches two things on the receive side: the silence that follows a received character, and the low-line conditions that mean a break. The receiver supplies a strobe for each bit period, the current line level and a pulse for each complete character. The block supplies a buffer-close pulse with an interrupt request, the length of the most recent break and a running break count.

All time is measured in whole characters. A character's length in bits is computed from the frame configuration. It is one start bit, plus the data width, plus a parity bit when parity is on, plus one or two stop bits. The idle time-out counts full characters of continuous high line after the last received character. Break length counts full characters of continuous low line. Start-bit detection and deserialisation belong to the receiver and are not part of this block.

Top module: `uart_idle_brk_mon`

## Requirements
- R1: The character length is 2 + D + P + S bits. D is `cfg_data_bits` clamped to the range 5 to 14, P is `cfg_parity_en` and S is `cfg_two_stop` (so 8 data bits, no parity and one stop bit give 10).
- R2: After a `char_done` pulse with `cfg_max_idle` = M > 0, the M·L-th consecutive high bit tick (L = character length) makes `buf_close` high for exactly one cycle, beginning the cycle after that tick. `irq` rises in the same cycle.
- R3: A `char_done` pulse reloads the idle count to M and restarts the partial character. A `char_done` that coincides with the tick that would have completed the gap suppresses the close.
- R4: With `cfg_max_idle` = 0, idle time never produces `buf_close` or `irq`.
- R5: After a time-out, no further `buf_close` occurs until the next `char_done`, however long the line stays idle.
- R6: `irq` stays high after a time-out until the next `char_done`, which clears it.
- R7: When the line returns high after a low run of N bit ticks with N ≥ L, `brk_len` becomes floor(N / L) one cycle after the high tick. A low run shorter than L leaves `brk_len` unchanged.
- R8: `brk_events` increases by exactly one for each low run of at least L bits, whatever the run's length. It never increases for a shorter run, and it wraps modulo 2^16.
- R9: Synchronous reset clears `buf_close`, `irq`, `brk_len` and `brk_events` to zero.
- R10: A low bit tick during an idle gap discards only the partially counted idle character. Full idle characters already counted are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe, once per bit period |
| rx_line | input | 1 | Receive line level, sampled on `bit_tick` |
| char_done | input | 1 | One-cycle pulse per received character |
| cfg_data_bits | input | 4 | Data bits per character (5 to 14, clamped) |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_two_stop | input | 1 | Two stop bits when high, one when low |
| cfg_max_idle | input | 16 | Idle characters before time-out; 0 disables |
| buf_close | output | 1 | One-cycle pulse on idle time-out |
| irq | output | 1 | Interrupt request, held until next `char_done` |
| brk_len | output | 16 | Length of the last break, in characters |
| brk_events | output | 16 | Break count, wraps at 16 bits |

## Verification
A received character and the final idle bit of a time-out can arrive in the same cycle. The bench provokes this by running the line high for M·L − 1 ticks and then asserting `char_done` together with the L-th tick of the last idle character. It judges the result by requiring that no close appears in that cycle, and that a close appears exactly one full gap later. A bound checker also requires, after every `char_done` cycle, that `buf_close` and `irq` are low. Every frame format is swept, with time-out positions and break lengths computed arithmetically from the character-length formula.

// File: rtl/uibm_pkg.sv
package uibm_pkg;

    localparam int CLEN_W = 5;

    function automatic logic [CLEN_W-1:0] frame_bits(input logic [3:0] dbits,
                                                     input logic       par,
                                                     input logic       two);
        logic [3:0] d;
        if (dbits < 4'd5)
            d = 4'd5;
        else if (dbits > 4'd14)
            d = 4'd14;
        else
            d = dbits;
        return CLEN_W'(2) + {1'b0, d} + {4'b0, par} + {4'b0, two};
    endfunction

endpackage

// File: rtl/uibm_char_len.sv
module uibm_char_len
    import uibm_pkg::*;
(
    input  logic [3:0]        data_bits,
    input  logic              parity_en,
    input  logic              two_stop,
    output logic [CLEN_W-1:0] clen
);
    always_comb begin
        clen = frame_bits(data_bits, parity_en, two_stop);
    end
endmodule

// File: rtl/uibm_idle_timer.sv
module uibm_idle_timer
    import uibm_pkg::*;
#(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              rx_line,
    input  logic              char_done,
    input  logic [CLEN_W-1:0] clen,
    input  logic [IDLE_W-1:0] max_idle,
    output logic              close_o,
    output logic              irq_o
);
    typedef struct packed {
        logic              armed;
        logic [IDLE_W-1:0] left;
        logic [CLEN_W-1:0] bits;
        logic              close;
        logic              irq;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.close = 1'b0;
        if (char_done) begin
            st_d.armed = (max_idle != '0);
            st_d.left  = max_idle;
            st_d.bits  = '0;
            st_d.irq   = 1'b0;
        end else if (bit_tick && st_q.armed) begin
            if (!rx_line) begin
                st_d.bits = '0;
            end else if (st_q.bits == clen - CLEN_W'(1)) begin
                st_d.bits = '0;
                if (st_q.left == IDLE_W'(1)) begin
                    st_d.armed = 1'b0;
                    st_d.left  = '0;
                    st_d.close = 1'b1;
                    st_d.irq   = 1'b1;
                end else begin
                    st_d.left = st_q.left - IDLE_W'(1);
                end
            end else begin
                st_d.bits = st_q.bits + CLEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign close_o = st_q.close;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/uibm_break_meter.sv
module uibm_break_meter
    import uibm_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int EVT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              rx_line,
    input  logic [CLEN_W-1:0] clen,
    output logic [LEN_W-1:0]  len_o,
    output logic [EVT_W-1:0]  evt_o
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef struct packed {
        logic              in_brk;
        logic [CLEN_W-1:0] bits;
        logic [LEN_W-1:0]  chars;
        logic [LEN_W-1:0]  last;
        logic [EVT_W-1:0]  evts;
    } brk_st_t;

    brk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_tick) begin
            if (!rx_line) begin
                if (st_q.bits == clen - CLEN_W'(1)) begin
                    st_d.bits = '0;
                    if (st_q.chars != LEN_MAX)
                        st_d.chars = st_q.chars + LEN_W'(1);
                    if (!st_q.in_brk) begin
                        st_d.in_brk = 1'b1;
                        st_d.evts   = st_q.evts + EVT_W'(1);
                    end
                end else begin
                    st_d.bits = st_q.bits + CLEN_W'(1);
                end
            end else begin
                if (st_q.in_brk) begin
                    st_d.last   = st_q.chars;
                    st_d.in_brk = 1'b0;
                end
                st_d.bits  = '0;
                st_d.chars = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign len_o = st_q.last;
    assign evt_o = st_q.evts;
endmodule

// File: rtl/uart_idle_brk_mon.sv
module uart_idle_brk_mon
    import uibm_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int LEN_W  = 16,
    parameter int EVT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              rx_line,
    input  logic              char_done,
    input  logic [3:0]        cfg_data_bits,
    input  logic              cfg_parity_en,
    input  logic              cfg_two_stop,
    input  logic [IDLE_W-1:0] cfg_max_idle,
    output logic              buf_close,
    output logic              irq,
    output logic [LEN_W-1:0]  brk_len,
    output logic [EVT_W-1:0]  brk_events
);
    logic [CLEN_W-1:0] clen;

    uibm_char_len u_len (
        .data_bits (cfg_data_bits),
        .parity_en (cfg_parity_en),
        .two_stop  (cfg_two_stop),
        .clen      (clen)
    );

    uibm_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .rx_line   (rx_line),
        .char_done (char_done),
        .clen      (clen),
        .max_idle  (cfg_max_idle),
        .close_o   (buf_close),
        .irq_o     (irq)
    );

    uibm_break_meter #(.LEN_W(LEN_W), .EVT_W(EVT_W)) u_brk (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .rx_line  (rx_line),
        .clen     (clen),
        .len_o    (brk_len),
        .evt_o    (brk_events)
    );
endmodule

// File: rtl/uibm_checker.sv
module uibm_checker #(
    parameter int IDLE_W = 16,
    parameter int LEN_W  = 16,
    parameter int EVT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_tick,
    input logic              rx_line,
    input logic              char_done,
    input logic [IDLE_W-1:0] cfg_max_idle,
    input logic              buf_close,
    input logic              irq,
    input logic [LEN_W-1:0]  brk_len,
    input logic [EVT_W-1:0]  brk_events
);
    assert_close_single_R2: assert property (@(posedge clk) disable iff (rst)
        buf_close |=> !buf_close);

    assert_close_raises_irq_R2: assert property (@(posedge clk) disable iff (rst)
        buf_close |-> irq);

    assert_char_suppresses_close_R3: assert property (@(posedge clk) disable iff (rst)
        char_done |=> !buf_close);

    assert_zero_max_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_max_idle == '0 && char_done) |=> !buf_close);

    assert_char_clears_irq_R6: assert property (@(posedge clk) disable iff (rst)
        char_done |=> !irq);

    assert_len_on_high_tick_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(brk_len) |-> ($past(bit_tick) && $past(rx_line)));

    assert_evt_step_one_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(brk_events) |-> (brk_events == $past(brk_events) + EVT_W'(1)));

    assert_evt_on_low_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(brk_events) |-> ($past(bit_tick) && !$past(rx_line)));
endmodule

bind uart_idle_brk_mon uibm_checker #(
    .IDLE_W(IDLE_W), .LEN_W(LEN_W), .EVT_W(EVT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_tick     (bit_tick),
    .rx_line      (rx_line),
    .char_done    (char_done),
    .cfg_max_idle (cfg_max_idle),
    .buf_close    (buf_close),
    .irq          (irq),
    .brk_len      (brk_len),
    .brk_events   (brk_events)
);

// File: tb/sim_uart_idle_brk_mon.sv
`timescale 1ns/1ps
module sim_uart_idle_brk_mon;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0;
    logic        rx_line = 1'b1;
    logic        char_done = 1'b0;
    logic [3:0]  cfg_data_bits = 4'd8;
    logic        cfg_parity_en = 1'b0;
    logic        cfg_two_stop = 1'b0;
    logic [15:0] cfg_max_idle = 16'd0;
    logic        buf_close;
    logic        irq;
    logic [15:0] brk_len;
    logic [15:0] brk_events;

    int n_chk = 0;
    int n_bad = 0;
    logic s_close, s_irq;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_idle_brk_mon u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_line(rx_line),
        .char_done(char_done), .cfg_data_bits(cfg_data_bits),
        .cfg_parity_en(cfg_parity_en), .cfg_two_stop(cfg_two_stop),
        .cfg_max_idle(cfg_max_idle), .buf_close(buf_close), .irq(irq),
        .brk_len(brk_len), .brk_events(brk_events)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic lvl, input logic cd);
        @(negedge clk);
        rx_line   = lvl;
        bit_tick  = 1'b1;
        char_done = cd;
        @(negedge clk);
        bit_tick  = 1'b0;
        char_done = 1'b0;
        s_close   = buf_close;
        s_irq     = irq;
        @(negedge clk);
    endtask

    function automatic int exp_len(input int d, input int p, input int s);
        int dc;
        dc = (d < 5) ? 5 : (d > 14) ? 14 : d;
        return 2 + dc + p + s;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
        end
    end

    initial begin
        int first, closes, ev0, len0, L, m, k;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 buf_close", buf_close, 0);
        check("R9 irq", irq, 0);
        check("R9 brk_len", brk_len, 0);
        check("R9 brk_events", brk_events, 0);
        rst = 1'b0;

        // R1 R2 R5 R6 R7 R8: sweep every frame format
        for (int d = 4; d <= 15; d++) begin
            for (int p = 0; p < 2; p++) begin
                for (int s = 0; s < 2; s++) begin
                    cfg_data_bits = 4'(d);
                    cfg_parity_en = 1'(p);
                    cfg_two_stop  = 1'(s);
                    L = exp_len(d, p, s);
                    m = 1 + (d % 3);
                    cfg_max_idle = 16'(m);
                    tick(1'b1, 1'b1);
                    first = -1;
                    closes = 0;
                    for (int i = 1; i <= m * L + L; i++) begin
                        tick(1'b1, 1'b0);
                        if (s_close) begin
                            closes++;
                            if (first < 0) first = i;
                        end
                    end
                    check("R1 R2 time-out position", first, m * L);
                    check("R5 single close per gap", closes, 1);
                    check("R6 irq held", s_irq, 1);
                    // R7 R8: break of k full characters plus a partial one
                    k = 1 + (d % 2);
                    ev0 = brk_events;
                    for (int i = 0; i < k * L + L - 1; i++) tick(1'b0, 1'b0);
                    check("R8 one event during break", brk_events, (ev0 + 1) & 16'hFFFF);
                    tick(1'b1, 1'b0);
                    check("R7 break length", brk_len, k);
                    check("R8 event count after end", brk_events, (ev0 + 1) & 16'hFFFF);
                    // R7 R8: short low run
                    len0 = brk_len;
                    ev0  = brk_events;
                    for (int i = 0; i < L - 1; i++) tick(1'b0, 1'b0);
                    tick(1'b1, 1'b0);
                    check("R7 short run keeps length", brk_len, len0);
                    check("R8 short run no event", brk_events, ev0);
                    tick(1'b1, 1'b1);
                    check("R6 irq cleared by char", s_irq, 0);
                end
            end
        end

        // remaining cases at 8 data bits, no parity, one stop: L = 10
        cfg_data_bits = 4'd8;
        cfg_parity_en = 1'b0;
        cfg_two_stop  = 1'b0;

        // R4: zero disables
        cfg_max_idle = 16'd0;
        tick(1'b1, 1'b1);
        closes = 0;
        for (int i = 0; i < 60; i++) begin
            tick(1'b1, 1'b0);
            if (s_close || s_irq) closes++;
        end
        check("R4 no time-out when zero", closes, 0);

        // R3: char on the final idle tick wins
        cfg_max_idle = 16'd2;
        tick(1'b1, 1'b1);
        closes = 0;
        for (int i = 0; i < 19; i++) begin
            tick(1'b1, 1'b0);
            if (s_close) closes++;
        end
        tick(1'b1, 1'b1);
        if (s_close) closes++;
        check("R3 no close on collision", closes, 0);
        for (int i = 0; i < 19; i++) begin
            tick(1'b1, 1'b0);
            if (s_close) closes++;
        end
        check("R3 no close before reloaded gap", closes, 0);
        tick(1'b1, 1'b0);
        check("R3 close after full reloaded gap", s_close, 1);

        // R10: low bit discards only the partial idle character
        cfg_max_idle = 16'd2;
        tick(1'b1, 1'b1);
        closes = 0;
        for (int i = 0; i < 15; i++) begin
            tick(1'b1, 1'b0);
            if (s_close) closes++;
        end
        tick(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin
            tick(1'b1, 1'b0);
            if (s_close) closes++;
        end
        check("R10 no close after partial restart", closes, 0);
        tick(1'b1, 1'b0);
        check("R10 close keeps counted character", s_close, 1);

        // R9: reset in mid-operation
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 brk_events after reset", brk_events, 0);
        check("R9 brk_len after reset", brk_len, 0);
        check("R9 irq after reset", irq, 0);
        rst = 1'b0;

        finished = 1'b1;
        summary();
    end
endmodule